// File: doc/BRIEF.md
# Software Break Entry and Return Sequencer

This block runs the multi-cycle sequences an 8-bit CPU core needs to enter a software break handler and to come back from it. It holds the program counter, the 8-bit status word and the 8-bit stack pointer. It drives a byte-wide memory port for stack pushes, stack pops and vector fetches, with one access per cycle. A break pulse saves the return address and the status on the stack. It then loads the handler address from the shared break/table-call-zero vector, sets the break flag and clears the interrupt enable. A return pulse restores the status and the program counter from the stack. Two single-access sequences push and pop the status word alone.

The surrounding core starts one sequence at a time with a one-cycle pulse and waits for the one-cycle `done_o` strobe. While the block is idle, the core can load the program counter, the status and the stack pointer through write ports. The memory read path is combinational: `mem_rdata_i` must be valid in the same cycle that `mem_re_o` and `mem_addr_o` are presented.

Top module: `brk_entry_seq`

## Requirements
- R1: After reset the program counter is 0x0000, the status is 0x00 (break flag clear), the stack pointer is 0xFF, and `busy_o` and `done_o` are low.
- R2: A break pushes the program counter high byte, then its low byte, then the status word. Each byte is written at address 0x0100 plus the current stack pointer, and the pointer is then decremented, wrapping within 8 bits. The status byte pushed is its value before the break.
- R3: Every stack access, push or pop, uses address high byte 0x01, and the pointer supplies the low byte.
- R4: After its pushes, a break reads the vector low byte at 0xFFDE and the high byte at 0xFFDF and loads them into the program counter. In the status word (bit 7..0 = N V P B H I Z C) it sets B (bit 4) and clears I (bit 2) and leaves the other bits unchanged.
- R5: A return pops the status, then the program counter low byte, then its high byte. Each pop first increments the pointer and then reads 0x0100 plus the new pointer. All eight status bits, B included, take the popped value.
- R6: A status push writes the status byte at 0x0100 plus the pointer and decrements the pointer. A status pop increments the pointer, reads the byte there and loads it into the status word, B included.
- R7: `done_o` is high for exactly one cycle per sequence. Counting the clock edge that samples the start pulse as edge 1, `done_o` is high after edge 6 for a break, edge 4 for a return, and edge 2 for a status push or pop.
- R8: Start pulses and register write strobes that arrive while `busy_o` is high have no effect on the sequence or its result.
- R9: When several start pulses arrive together in idle, only one sequence runs, chosen in the priority order break, return, status push, status pop.
- R10: In idle, a write strobe loads its register at the next clock edge, and the new value appears on `pc_o`, `psw_o` or `sp_o`.
- R11: In no cycle are `mem_we_o` and `mem_re_o` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_i | input | 1 | Start a break entry (one-cycle pulse) |
| rti_i | input | 1 | Start a return from break |
| php_i | input | 1 | Start a status push |
| plp_i | input | 1 | Start a status pop |
| pc_we_i | input | 1 | Load program counter (idle only) |
| pc_wdata_i | input | 16 | Program counter load value |
| psw_we_i | input | 1 | Load status word (idle only) |
| psw_wdata_i | input | 8 | Status load value |
| sp_we_i | input | 1 | Load stack pointer (idle only) |
| sp_wdata_i | input | 8 | Stack pointer load value |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| pc_o | output | 16 | Program counter |
| psw_o | output | 8 | Status word |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A corrupted sequencer state shows at the memory port at the next access. The address, the strobe kind or the write data for that cycle come out wrong, so a stuck or skipped state is seen within one cycle, and a wrong `done_o` latency is seen at completion. A wrong stack pointer shows as a wrong stack address at the next push or pop, and as a wrong `sp_o` value once the sequence ends. Faults in the status or program counter updates are visible on `psw_o` and `pc_o` in the cycle `done_o` rises. The bench compares them there against a model of the stack it writes itself, and it compares the bytes that landed in its stack memory.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_PCH,
    S_PUSH_PCL,
    S_PUSH_PSW,
    S_VEC_LO,
    S_VEC_HI,
    S_POP_PSW,
    S_POP_PCL,
    S_POP_PCH
  } seq_state_e;

  localparam int PSW_B = 4;
  localparam int PSW_I = 2;
endpackage

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl
  import brk_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_i,
  input  logic       rti_i,
  input  logic       php_i,
  input  logic       plp_i,
  output seq_state_e state_o,
  output logic       busy_o,
  output logic       last_o,
  output logic       full_o
);
  seq_state_e state_q, state_d;
  logic       full_q, full_d;

  always_comb begin
    state_d = state_q;
    full_d  = full_q;
    unique case (state_q)
      S_IDLE: begin
        if (brk_i) begin
          state_d = S_PUSH_PCH; full_d = 1'b1;
        end else if (rti_i) begin
          state_d = S_POP_PSW;  full_d = 1'b1;
        end else if (php_i) begin
          state_d = S_PUSH_PSW; full_d = 1'b0;
        end else if (plp_i) begin
          state_d = S_POP_PSW;  full_d = 1'b0;
        end
      end
      S_PUSH_PCH: state_d = S_PUSH_PCL;
      S_PUSH_PCL: state_d = S_PUSH_PSW;
      S_PUSH_PSW: state_d = full_q ? S_VEC_LO : S_IDLE;
      S_VEC_LO:   state_d = S_VEC_HI;
      S_VEC_HI:   state_d = S_IDLE;
      S_POP_PSW:  state_d = full_q ? S_POP_PCL : S_IDLE;
      S_POP_PCL:  state_d = S_POP_PCH;
      S_POP_PCH:  state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      full_q  <= full_d;
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != S_IDLE);
  assign full_o  = full_q;
  assign last_o  = (state_q == S_VEC_HI) || (state_q == S_POP_PCH) ||
                   (((state_q == S_PUSH_PSW) || (state_q == S_POP_PSW)) && !full_q);

  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PUSH_PCH) |=> (state_q == S_PUSH_PCL)); // R8
  AST_PRIO_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_IDLE) && brk_i) |=> (state_q == S_PUSH_PCH)); // R9
endmodule

// File: rtl/brk_seq_stack.sv
module brk_seq_stack #(
  parameter int          SP_W     = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [ADDR_W-SP_W-1:0] PAGE = 'h01,
  parameter logic [SP_W-1:0] SP_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              ld_i,
  input  logic [SP_W-1:0]   ld_val_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SP_W-1:0] sp_q, sp_inc;

  assign sp_inc = sp_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= SP_RST;
    else if (ld_i)    sp_q <= ld_val_i;
    else if (push_i)  sp_q <= sp_q - 1'b1;
    else if (pop_i)   sp_q <= sp_inc;
  end

  // pop pre-increments, push post-decrements
  assign addr_o = {PAGE, (pop_i ? sp_inc : sp_q)};
  assign sp_o   = sp_q;

  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !ld_i) |=> (sp_q == $past(sp_q) - 1'b1)); // R2
  AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !ld_i) |=> (sp_q == $past(sp_q) + 1'b1)); // R5
endmodule

// File: rtl/brk_entry_seq.sv
module brk_entry_seq
  import brk_seq_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFDE,
  parameter logic [DATA_W-1:0] SP_RST   = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              brk_i,
  input  logic              rti_i,
  input  logic              php_i,
  input  logic              plp_i,
  input  logic              pc_we_i,
  input  logic [ADDR_W-1:0] pc_wdata_i,
  input  logic              psw_we_i,
  input  logic [DATA_W-1:0] psw_wdata_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] psw_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PAGE_W = ADDR_W - DATA_W;
  localparam logic [PAGE_W-1:0] STK_PAGE = 'h01;

  seq_state_e        state;
  logic              busy, last, full;
  logic              push, pop, vec_rd, idle_ld;
  logic [ADDR_W-1:0] stk_addr;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] psw_q, vec_lo_q;
  logic              done_q;

  brk_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .brk_i, .rti_i, .php_i, .plp_i,
    .state_o(state), .busy_o(busy), .last_o(last), .full_o(full)
  );

  assign push    = (state == S_PUSH_PCH) || (state == S_PUSH_PCL) || (state == S_PUSH_PSW);
  assign pop     = (state == S_POP_PSW)  || (state == S_POP_PCL)  || (state == S_POP_PCH);
  assign vec_rd  = (state == S_VEC_LO)   || (state == S_VEC_HI);
  assign idle_ld = !busy;

  brk_seq_stack #(
    .SP_W(DATA_W), .ADDR_W(ADDR_W), .PAGE(STK_PAGE), .SP_RST(SP_RST)
  ) u_stack (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop),
    .ld_i(idle_ld && sp_we_i), .ld_val_i(sp_wdata_i),
    .sp_o(sp_o), .addr_o(stk_addr)
  );

  always_comb begin
    mem_addr_o = stk_addr;
    if (state == S_VEC_LO) mem_addr_o = VEC_ADDR;
    if (state == S_VEC_HI) mem_addr_o = VEC_ADDR + 1'b1;
  end

  assign mem_we_o = push;
  assign mem_re_o = pop || vec_rd;

  always_comb begin
    unique case (state)
      S_PUSH_PCH: mem_wdata_o = pc_q[ADDR_W-1:DATA_W];
      S_PUSH_PCL: mem_wdata_o = pc_q[DATA_W-1:0];
      default:    mem_wdata_o = psw_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      psw_q    <= '0;
      vec_lo_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (idle_ld) begin
        if (pc_we_i)  pc_q  <= pc_wdata_i;
        if (psw_we_i) psw_q <= psw_wdata_i;
      end
      unique case (state)
        S_PUSH_PSW: if (full) begin
          psw_q[PSW_B] <= 1'b1;
          psw_q[PSW_I] <= 1'b0;
        end
        S_VEC_LO:  vec_lo_q <= mem_rdata_i;
        S_VEC_HI:  pc_q     <= {mem_rdata_i, vec_lo_q};
        S_POP_PSW: psw_q    <= mem_rdata_i;
        S_POP_PCL: pc_q[DATA_W-1:0]      <= mem_rdata_i;
        S_POP_PCH: pc_q[ADDR_W-1:DATA_W] <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign pc_o   = pc_q;
  assign psw_o  = psw_q;
  assign busy_o = busy;
  assign done_o = done_q;

  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R11
  AST_STACK_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push || pop) |-> (mem_addr_o[ADDR_W-1:DATA_W] == STK_PAGE)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BRK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_VEC_HI) |=> (psw_o[PSW_B] && !psw_o[PSW_I] && done_o)); // R4
  AST_PC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push || state == S_VEC_LO) |=> $stable(pc_o)); // R8
endmodule

// File: tb/sim_brk_entry_seq.sv
`timescale 1ns/1ps
module sim_brk_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        brk = 0, rti = 0, php = 0, plp = 0;
  logic        pc_we = 0, psw_we = 0, sp_we = 0;
  logic [15:0] pc_wd = '0;
  logic [7:0]  psw_wd = '0, sp_wd = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] pc;
  logic [7:0]  psw, sp;
  logic        busy, done;

  logic [7:0]  stk [256];
  logic [7:0]  vec_lo = 8'h34, vec_hi = 8'h12;

  int unsigned checks = 0, errors = 0;
  logic [15:0] e_pc;
  logic [7:0]  e_psw, e_sp;

  always #2.5 clk = ~clk;

  brk_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .brk_i(brk), .rti_i(rti), .php_i(php), .plp_i(plp),
    .pc_we_i(pc_we), .pc_wdata_i(pc_wd),
    .psw_we_i(psw_we), .psw_wdata_i(psw_wd),
    .sp_we_i(sp_we), .sp_wdata_i(sp_wd),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .psw_o(psw), .sp_o(sp), .busy_o(busy), .done_o(done)
  );

  always_comb begin
    if (mem_addr == 16'hFFDE)           mem_rdata = vec_lo;
    else if (mem_addr == 16'hFFDF)      mem_rdata = vec_hi;
    else if (mem_addr[15:8] == 8'h01)   mem_rdata = stk[mem_addr[7:0]];
    else                                mem_rdata = 8'h00;
  end

  always @(posedge clk)
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n) begin
      checks++;
      if (mem_we && mem_re) begin
        errors++;
        $display("FAIL R11 actual=we&re expected=one");
      end
      if ((mem_we || (mem_re && mem_addr[15:1] != 15'h7FEF)) && mem_addr[15:8] != 8'h01) begin
        errors++;
        $display("FAIL R3 actual=%0h expected=01xx", mem_addr);
      end
    end

  function automatic logic [7:0] brk_psw(input logic [7:0] p);
    return (p | 8'h10) & 8'hFB;
  endfunction

  task automatic load(input logic [15:0] p, input logic [7:0] s, input logic [7:0] k);
    @(negedge clk);
    pc_we = 1; psw_we = 1; sp_we = 1; pc_wd = p; psw_wd = s; sp_wd = k;
    @(negedge clk);
    pc_we = 0; psw_we = 0; sp_we = 0;
    e_pc = p; e_psw = s; e_sp = k;
    chk("R10 pc", pc, p); chk("R10 psw", psw, s); chk("R10 sp", sp, k);
  endtask

  // kind: 0 brk, 1 rti, 2 php, 3 plp; interfere pulses junk while busy
  task automatic run(input int kind, input bit interfere);
    int lat, exp_lat;
    logic [7:0] s0;
    s0 = e_sp;
    unique case (kind)
      0: exp_lat = 6;
      1: exp_lat = 4;
      default: exp_lat = 2;
    endcase
    @(negedge clk);
    brk = (kind == 0); rti = (kind == 1); php = (kind == 2); plp = (kind == 3);
    @(negedge clk);
    brk = 0; rti = 0; php = 0; plp = 0;
    lat = 1;
    while (!done && lat < 20) begin
      if (interfere && lat == 2) begin
        brk = 1; rti = 1; php = 1; plp = 1; pc_we = 1; psw_we = 1; sp_we = 1;
        pc_wd = 16'hDEAD; psw_wd = 8'hA5; sp_wd = 8'h5A;
      end else begin
        brk = 0; rti = 0; php = 0; plp = 0; pc_we = 0; psw_we = 0; sp_we = 0;
      end
      @(negedge clk);
      lat++;
    end
    brk = 0; rti = 0; php = 0; plp = 0; pc_we = 0; psw_we = 0; sp_we = 0;
    chk(interfere ? "R8 latency" : "R7 latency", lat, exp_lat);
    unique case (kind)
      0: begin
        chk("R2 push pch", stk[s0], e_pc[15:8]);
        chk("R2 push pcl", stk[s0 - 8'd1], e_pc[7:0]);
        chk("R2 push psw", stk[s0 - 8'd2], e_psw);
        e_sp = s0 - 8'd3; e_pc = {vec_hi, vec_lo}; e_psw = brk_psw(e_psw);
      end
      1: begin
        e_psw = stk[s0 + 8'd1];
        e_pc  = {stk[s0 + 8'd3], stk[s0 + 8'd2]};
        e_sp  = s0 + 8'd3;
      end
      2: begin
        chk("R6 php byte", stk[s0], e_psw);
        e_sp = s0 - 8'd1;
      end
      default: begin
        e_psw = stk[s0 + 8'd1];
        e_sp  = s0 + 8'd1;
      end
    endcase
    chk(kind == 0 ? "R4 pc" : kind == 1 ? "R5 pc" : "R6 pc", pc, e_pc);
    chk(kind == 0 ? "R4 psw" : kind == 1 ? "R5 psw" : "R6 psw", psw, e_psw);
    chk(kind == 0 ? "R2 sp" : kind == 1 ? "R5 sp" : "R6 sp", sp, e_sp);
    @(negedge clk);
    chk("R7 done one cycle", done, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) stk[i] = 8'(i);
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc", pc, 16'h0000); chk("R1 psw", psw, 8'h00);
    chk("R1 sp", sp, 8'hFF); chk("R1 busy", busy, 1'b0); chk("R1 done", done, 1'b0);
    e_pc = 16'h0000; e_psw = 8'h00; e_sp = 8'hFF;

    // directed: break with SP wrap through page bottom, then return
    load(16'h8421, 8'hCF, 8'h01);
    run(0, 0);
    run(1, 0);
    // R5: popped status may clear B
    load(16'h1000, 8'h10, 8'h40);
    stk[8'h41] = 8'h04; stk[8'h42] = 8'hBB; stk[8'h43] = 8'hAA;
    run(1, 0);
    // R6: status pop sets B
    stk[e_sp + 8'd1] = 8'h10;
    run(3, 0);
    run(2, 0);
    // R9: break and pop together -> break runs (6-edge latency, vector loaded)
    @(negedge clk);
    brk = 1; plp = 1;
    @(negedge clk);
    brk = 0; plp = 0;
    repeat (5) @(negedge clk);
    chk("R9 brk wins done", done, 1'b1);
    chk("R9 brk wins pc", pc, {vec_hi, vec_lo});
    e_sp = e_sp - 8'd3; e_psw = brk_psw(e_psw); e_pc = {vec_hi, vec_lo};
    chk("R9 sp", sp, e_sp);
    // R9: return and push together -> return runs
    @(negedge clk);
    rti = 1; php = 1;
    @(negedge clk);
    rti = 0; php = 0;
    repeat (3) @(negedge clk);
    chk("R9 rti wins done", done, 1'b1);
    e_sp = e_sp + 8'd3;
    chk("R9 rti sp", sp, e_sp);
    e_psw = psw; e_pc = pc;
    // R8: interference during break
    run(0, 1);

    for (int n = 0; n < 300; n++) begin
      int k;
      k = $urandom % 6;
      vec_lo = 8'($urandom); vec_hi = 8'($urandom);
      if (k == 1)
        for (int j = 1; j <= 3; j++) stk[e_sp + 8'(j)] = 8'($urandom);
      if (k == 3) stk[e_sp + 8'd1] = 8'($urandom);
      if (k == 4) load(16'($urandom), 8'($urandom), 8'($urandom));
      else if (k == 5) run(0, 1);
      else run(k, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule